// File: doc/BRIEF.md
# NAND Flash Strobe Timing Sequencer

This block turns single bus-cycle requests into correctly timed strobes on an 8-bit NAND flash interface. A request carries one of four cycle kinds: command latch, address latch, data write or data read. For each one the sequencer drives chip enable, the command and address latch enables, write enable, read enable and the data-bus drive enable. Every edge is placed on a quarter-cycle tick. The block runs on one fast clock at four times the bus rate, so one bus clock equals four ticks.

A small configuration word sets the timing. It has a 3-bit wait count, a 2-bit write-hold code, a 2-bit read-setup code and a relaxed bit. The wait count, the turnaround gap before data transfers and the busy-blanking window after a command all scale from the same base of (2 + wait count) bus clocks. The relaxed bit doubles that base and lengthens setup and hold. The word is captured when a request is accepted, so later changes do not touch a cycle already in progress.

After a command cycle, the ready/busy line is ignored for a blanking window. Once the window ends, the line is watched through a two-flop synchroniser. A done pulse, four ticks wide, closes every cycle. For reads, the captured byte is presented with that pulse.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, nf_ce_n, nf_we_n and nf_re_n are 1, nf_cle, nf_ale, nf_dq_oe and done are 0, and the quarter-phase counter starts at 0.
- R2: req_ready is 1 only while the sequencer is idle and the phase counter is at its last quarter (3). A request is accepted on a rising clk4x edge where req_valid and req_ready are both 1. req_kind encodes 00 command, 01 address, 10 data write and 11 data read.
- R3: A cycle starts with a setup segment of 4 ticks (8 if relaxed), in which nf_ce_n is 0 and the strobes are inactive. nf_ce_n stays 0 through the strobe and hold segments. nf_cle is 1 through those segments for commands, and nf_ale is 1 for addresses. For all three write kinds, nf_dq_oe is 1 and nf_dq_out carries the request data.
- R4: For write kinds, nf_we_n is 0 for 4×(1+W) ticks, where W is the wait count (2× the wait count when relaxed).
- R5: After a write strobe, nf_ce_n stays 0 for a hold of 2, 4, 6 or 8 ticks for hold codes 00, 01, 10 and 11, plus 4 ticks when relaxed.
- R6: For reads, nf_re_n is 0 for S + 4×W ticks plus 4 more when relaxed. S is 3, 4, 2 or 4 ticks for read-setup codes 00, 01, 10 and 11. nf_dq_in is captured on the last tick of that strobe. The read hold is 4 ticks, or 8 when relaxed.
- R7: A turnaround gap of 16×(2+wait count) ticks (doubled when relaxed), with all outputs idle, comes before the setup segment in two cases: a data write or read following a command or address cycle, and a read following a data write.
- R8: After a command cycle's hold, a blanking window of 32×(2+wait count) ticks (doubled when relaxed) passes. The cycle then waits until nf_rb, delayed by two clk4x flops, is 1.
- R9: Every cycle ends with done at 1 for exactly 4 ticks, then returns to idle. rd_data holds the captured read byte while done is 1.
- R10: Configuration inputs changed after acceptance do not alter the timing of the cycle in progress.
- R11: nf_we_n and nf_re_n are never 0 together, and nf_dq_oe is 0 whenever nf_re_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk4x | input | 1 | Fast clock, four ticks per bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hold | input | 2 | Write-hold code |
| cfg_wait | input | 3 | Wait-state count |
| cfg_rdsetup | input | 2 | Read-setup code |
| cfg_relax | input | 1 | Relaxed timing |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this tick |
| req_kind | input | 2 | Cycle kind |
| req_wdata | input | 8 | Byte for write kinds |
| done | output | 1 | Cycle complete, 4 ticks |
| rd_data | output | 8 | Captured read byte |
| nf_ce_n | output | 1 | Chip enable, low active |
| nf_we_n | output | 1 | Write strobe, low active |
| nf_re_n | output | 1 | Read strobe, low active |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_dq_oe | output | 1 | Data bus drive enable |
| nf_dq_out | output | 8 | Data bus out |
| nf_dq_in | input | 8 | Data bus in |
| nf_rb | input | 1 | Ready/busy, high when ready |

## Verification
Every output is a decode of registered state, so each result changes on the tick edge after the cause. Acceptance shows on the edge after req_valid meets req_ready. Each segment boundary lands exactly its tick count after the previous one. A ready/busy rise is seen two edges after it reaches the synchroniser input. The bench steps its own segment list on every rising edge, including its own two-stage copy of ready/busy. It compares all outputs at the following falling edge, so every check lands in the tick the requirement sets, with no tolerance window.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {K_CMD = 2'b00, K_ADDR = 2'b01, K_WR = 2'b10, K_RD = 2'b11} kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_SETUP, S_STROBE, S_HOLD, S_BLANK, S_WAITRB, S_DONE
  } seg_e;

  typedef struct packed {
    logic [1:0] hold;
    logic [2:0] waits;
    logic [1:0] rdsu;
    logic       relax;
  } cfg_t;

  localparam int unsigned TICKS_PER_BUS = 4;

  // effective wait states in bus clocks
  function automatic int unsigned eff_waits(cfg_t c);
    return c.relax ? 2 * int'(c.waits) : int'(c.waits);
  endfunction

  // base term (2 + waits) in bus clocks, doubled when relaxed
  function automatic int unsigned base_bus(cfg_t c);
    int unsigned b;
    b = 2 + int'(c.waits);
    return c.relax ? (b << 1) : b;
  endfunction

  function automatic int unsigned rd_setup_ticks(logic [1:0] code);
    case (code)
      2'b00:   return 3;
      2'b10:   return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int unsigned seg_ticks(seg_e s, cfg_t c, kind_e k);
    int unsigned rel;
    rel = c.relax ? TICKS_PER_BUS : 0;
    case (s)
      S_GAP:    return 4 * TICKS_PER_BUS * base_bus(c);
      S_SETUP:  return TICKS_PER_BUS + rel;
      S_STROBE: return (k == K_RD) ? rd_setup_ticks(c.rdsu) + TICKS_PER_BUS * eff_waits(c) + rel
                                   : TICKS_PER_BUS * (1 + eff_waits(c));
      S_HOLD:   return (k == K_RD) ? TICKS_PER_BUS + rel : 2 * int'(c.hold) + 2 + rel;
      S_BLANK:  return 8 * TICKS_PER_BUS * base_bus(c);
      S_DONE:   return TICKS_PER_BUS;
      default:  return 1;
    endcase
  endfunction

  // turnaround needed between previous and new cycle kinds
  function automatic logic needs_turn(kind_e prev, kind_e cur);
    logic prev_latch, cur_data;
    prev_latch = (prev == K_CMD) || (prev == K_ADDR);
    cur_data   = (cur == K_WR) || (cur == K_RD);
    return (prev_latch && cur_data) || (prev == K_WR && cur == K_RD);
  endfunction
endpackage

// File: rtl/nand_seq_phase.sv
module nand_seq_phase #(
  parameter int PW = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic last
);
  logic [PW-1:0] ph;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ph <= '0;
    else        ph <= ph + 1'b1;
  assign last = &ph;
endmodule

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end
  endgenerate
  assign q = sh[STAGES-1];
endmodule

// File: rtl/nand_seq_len.sv
module nand_seq_len
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  seg_e             seg,
  input  cfg_t             cfg,
  input  kind_e            kind,
  output logic [CNT_W-1:0] len_m1
);
  int unsigned t;
  always_comb begin
    t      = seg_ticks(seg, cfg, kind);
    len_m1 = CNT_W'(t - 1);
  end
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_seq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CNT_W    = 12,
  parameter int PHASE_W  = 2,
  parameter int SYNC_N   = 2
) (
  input  logic          clk4x,
  input  logic          rst_n,
  input  logic [1:0]    cfg_hold,
  input  logic [2:0]    cfg_wait,
  input  logic [1:0]    cfg_rdsetup,
  input  logic          cfg_relax,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          nf_ce_n,
  output logic          nf_we_n,
  output logic          nf_re_n,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic          nf_dq_oe,
  output logic [DW-1:0] nf_dq_out,
  input  logic [DW-1:0] nf_dq_in,
  input  logic          nf_rb
);
  seg_e             st, nxt, first_seg;
  cfg_t             cfg_in, cfg_q;
  kind_e            kind_in, kind_q;
  logic [DW-1:0]    wdata_q;
  logic [CNT_W-1:0] cnt, len_first, len_next;
  logic             ph_last, rb_ok, accept, seg_end, turn, in_bus, is_rd;

  assign cfg_in  = '{hold: cfg_hold, waits: cfg_wait, rdsu: cfg_rdsetup, relax: cfg_relax};
  assign kind_in = kind_e'(req_kind);

  nand_seq_phase #(.PW(PHASE_W)) u_phase (.clk(clk4x), .rst_n(rst_n), .last(ph_last));
  nand_seq_sync  #(.STAGES(SYNC_N)) u_sync (.clk(clk4x), .rst_n(rst_n), .d(nf_rb), .q(rb_ok));

  // events brought out for checks
  assign req_ready = (st == S_IDLE) && ph_last;
  assign accept    = req_valid && req_ready;
  assign seg_end   = (cnt == '0);
  assign turn      = needs_turn(kind_q, kind_in);
  assign first_seg = turn ? S_GAP : S_SETUP;

  always_comb begin
    case (st)
      S_GAP:    nxt = S_SETUP;
      S_SETUP:  nxt = S_STROBE;
      S_STROBE: nxt = S_HOLD;
      S_HOLD:   nxt = (kind_q == K_CMD) ? S_BLANK : S_DONE;
      S_BLANK:  nxt = S_WAITRB;
      S_WAITRB: nxt = S_DONE;
      default:  nxt = S_IDLE;
    endcase
  end

  nand_seq_len #(.CNT_W(CNT_W)) u_len_first (.seg(first_seg), .cfg(cfg_in), .kind(kind_in), .len_m1(len_first));
  nand_seq_len #(.CNT_W(CNT_W)) u_len_next  (.seg(nxt),       .cfg(cfg_q),  .kind(kind_q),  .len_m1(len_next));

  always_ff @(posedge clk4x or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      cfg_q   <= '0;
      kind_q  <= K_RD;
      wdata_q <= '0;
      rd_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          cfg_q   <= cfg_in;
          kind_q  <= kind_in;
          wdata_q <= req_wdata;
          st      <= first_seg;
          cnt     <= len_first;
        end
        S_WAITRB: if (rb_ok) begin
          st  <= nxt;
          cnt <= len_next;
        end
        default: if (seg_end) begin
          st  <= nxt;
          cnt <= len_next;
        end else begin
          cnt <= cnt - 1'b1;
        end
      endcase
      if (st == S_STROBE && seg_end && kind_q == K_RD)
        rd_data <= nf_dq_in;
    end
  end

  assign is_rd     = (kind_q == K_RD);
  assign in_bus    = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
  assign nf_ce_n   = !in_bus;
  assign nf_cle    = in_bus && (kind_q == K_CMD);
  assign nf_ale    = in_bus && (kind_q == K_ADDR);
  assign nf_dq_oe  = in_bus && !is_rd;
  assign nf_we_n   = !((st == S_STROBE) && !is_rd);
  assign nf_re_n   = !((st == S_STROBE) && is_rd);
  assign nf_dq_out = wdata_q;
  assign done      = (st == S_DONE);

  AST_STROBE_EXCL: assert property (@(posedge clk4x) disable iff (!rst_n)
    nf_we_n || nf_re_n); // R11
  AST_READ_NO_DRIVE: assert property (@(posedge clk4x) disable iff (!rst_n)
    !nf_re_n |-> !nf_dq_oe); // R11
  AST_DONE_FOUR: assert property (@(posedge clk4x) disable iff (!rst_n)
    $rose(done) |-> ##1 done ##1 done ##1 done ##1 !done); // R9
  AST_CFG_HELD: assert property (@(posedge clk4x) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(cfg_q)); // R10
  AST_RB_AFTER_BLANK: assert property (@(posedge clk4x) disable iff (!rst_n)
    (st == S_WAITRB && $past(st) != S_WAITRB) |-> ($past(st) == S_BLANK && $past(cnt) == '0)); // R8
  AST_ACCEPT_ALIGN: assert property (@(posedge clk4x) disable iff (!rst_n)
    ($past(st) == S_IDLE && st != S_IDLE) |-> $past(ph_last)); // R2
  AST_GAP_DATA: assert property (@(posedge clk4x) disable iff (!rst_n)
    (st == S_GAP) |-> (kind_q == K_WR || kind_q == K_RD)); // R7
endmodule

// File: tb/sim_nand_strobe_seq.sv
module sim_nand_strobe_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk4x = 0, rst_n = 0;
  logic [1:0] cfg_hold = 0, cfg_rdsetup = 0, req_kind = 0;
  logic [2:0] cfg_wait = 0;
  logic       cfg_relax = 0, req_valid = 0, nf_rb = 1;
  logic [7:0] req_wdata = 0, nf_dq_in = 0;
  logic       req_ready, done, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe;
  logic [7:0] rd_data, nf_dq_out;

  nand_strobe_seq u0 (
    .clk4x(clk4x), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_wait(cfg_wait),
    .cfg_rdsetup(cfg_rdsetup), .cfg_relax(cfg_relax), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_wdata(req_wdata), .done(done),
    .rd_data(rd_data), .nf_ce_n(nf_ce_n), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_dq_oe(nf_dq_oe), .nf_dq_out(nf_dq_out),
    .nf_dq_in(nf_dq_in), .nf_rb(nf_rb));

  always #(CLK_PERIOD/2) clk4x = ~clk4x;

  int compared = 0, mismatched = 0, cycles = 0;

  // reference model: list of segments, each an output picture and a tick count (-1 = wait for ready)
  // picture bits: {ce_n, we_n, re_n, cle, ale, oe, done}
  localparam logic [6:0] IDLE_V = 7'b1110000;
  logic [6:0] seg_v[$];
  int         seg_n[$];
  logic [6:0] cur_v = IDLE_V;
  int         cur_rem = 0;
  bit         m_idle = 1, m_wait = 0, s1 = 0, s2 = 0;
  int         m_phase = 0, m_prev = 3;
  logic [7:0] m_wdata = 0, m_rd = 0;

  function automatic logic [6:0] pic(bit ce, bit we, bit re, bit cl, bit al, bit oe, bit dn);
    return {ce, we, re, cl, al, oe, dn};
  endfunction

  task automatic push(logic [6:0] v, int n);
    seg_v.push_back(v); seg_n.push_back(n);
  endtask

  task automatic advance();
    if (seg_v.size() == 0) begin
      m_idle = 1; m_wait = 0; cur_v = IDLE_V;
    end else begin
      cur_v = seg_v.pop_front();
      cur_rem = seg_n.pop_front();
      m_wait = (cur_rem < 0);
      cur_rem = cur_rem - 1;
    end
  endtask

  task automatic plan_cycle(int k, int h, int w, int r, int x);
    int mult, ws, gap, st, hd;
    bit cl, al, wr, turn;
    mult = x ? 2 : 1;
    ws   = w * mult;
    cl = (k == 0); al = (k == 1); wr = (k != 3);
    turn = ((m_prev <= 1) && (k >= 2)) || (m_prev == 2 && k == 3);
    gap  = turn ? 16 * (2 + w) * mult : 0;
    if (gap > 0) push(IDLE_V, gap);
    push(pic(0, 1, 1, cl, al, wr, 0), 4 * mult);
    if (wr) begin
      st = 4 + 4 * ws;
      hd = 2 + 2 * h + 4 * x;
      push(pic(0, 0, 1, cl, al, 1, 0), st);
      push(pic(0, 1, 1, cl, al, 1, 0), hd);
    end else begin
      st = ((r == 0) ? 3 : (r == 2) ? 2 : 4) + 4 * ws + 4 * x;
      push(pic(0, 1, 0, 0, 0, 0, 0), st);
      push(pic(0, 1, 1, 0, 0, 0, 0), 4 * mult);
    end
    if (k == 0) begin
      push(IDLE_V, 32 * (2 + w) * mult);
      push(IDLE_V, -1);
    end
    push(7'b1110001, 4);
    m_prev = k;
  endtask

  always @(posedge clk4x) begin
    bit old_s2;
    if (!rst_n) begin
      m_idle = 1; m_wait = 0; cur_v = IDLE_V; m_phase = 0; s1 = 0; s2 = 0; m_prev = 3;
      seg_v.delete(); seg_n.delete();
    end else begin
      old_s2 = s2;
      s2 = s1; s1 = nf_rb;
      if (m_idle) begin
        if (req_valid && m_phase == 3) begin
          m_wdata = req_wdata; m_rd = nf_dq_in; m_idle = 0;
          plan_cycle(req_kind, cfg_hold, cfg_wait, cfg_rdsetup, cfg_relax);
          advance();
        end
      end else if (m_wait) begin
        if (old_s2) advance();
      end else if (cur_rem > 0) cur_rem--;
      else advance();
      m_phase = (m_phase + 1) % 4;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk4x) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    if (rst_n) begin
      chk("R2", "req_ready", req_ready, m_idle && m_phase == 3);
      chk("R3", "nf_ce_n", nf_ce_n, cur_v[6]);
      chk("R4_R5", "nf_we_n", nf_we_n, cur_v[5]);
      chk("R6", "nf_re_n", nf_re_n, cur_v[4]);
      chk("R3", "nf_cle", nf_cle, cur_v[3]);
      chk("R3", "nf_ale", nf_ale, cur_v[2]);
      chk("R3", "nf_dq_oe", nf_dq_oe, cur_v[1]);
      chk("R9", "done", done, cur_v[0]);
      if (cur_v[1]) chk("R3", "nf_dq_out", nf_dq_out, m_wdata);
      if (cur_v[0] && m_prev == 3) chk("R9", "rd_data", rd_data, m_rd);
    end
  end

  // issue one request, scramble config right after acceptance (R10), wait for completion
  task automatic issue(int k, logic [7:0] d, int h, int w, int r, int x);
    @(negedge clk4x);
    req_kind = 2'(k); req_wdata = d; nf_dq_in = ~d;
    cfg_hold = 2'(h); cfg_wait = 3'(w); cfg_rdsetup = 2'(r); cfg_relax = x[0];
    req_valid = 1;
    while (!req_ready) @(negedge clk4x);
    @(negedge clk4x);
    req_valid = 0;
    cfg_hold = ~cfg_hold; cfg_wait = ~cfg_wait; cfg_rdsetup = ~cfg_rdsetup; cfg_relax = ~cfg_relax;
    while (!m_idle) @(negedge clk4x);
    repeat (2) @(negedge clk4x);
  endtask

  initial begin
    repeat (3) @(negedge clk4x);
    // R1: reset values while held in reset
    chk("R1", "nf_ce_n", nf_ce_n, 1);
    chk("R1", "nf_we_n", nf_we_n, 1);
    chk("R1", "nf_re_n", nf_re_n, 1);
    chk("R1", "latch/oe/done", {nf_cle, nf_ale, nf_dq_oe, done}, 0);
    rst_n = 1;
    // R1: phase starts at 0, so first ready appears on the fourth tick
    chk("R1", "req_ready t0", req_ready, 0);
    // R8: command with blanking, ready high
    issue(0, 8'h70, 1, 2, 0, 0);
    issue(1, 8'h12, 0, 0, 0, 0);
    // R7 + R5: data writes over all hold codes, first one after address gets the gap
    for (int h = 0; h < 4; h++) issue(2, 8'hA0 + 8'(h), h, 1, 0, 0);
    // R7 + R6: reads over all setup codes, first one after a write gets the gap
    for (int r = 0; r < 4; r++) issue(3, 8'h30 + 8'(r), 0, 1, r, 0);
    // relaxed variants: R4 R5 R6 R3
    issue(0, 8'hFF, 3, 3, 0, 1);
    issue(1, 8'h44, 0, 3, 0, 1);
    issue(2, 8'h5C, 3, 3, 0, 1);
    issue(3, 8'hC5, 0, 3, 2, 1);
    issue(2, 8'h11, 2, 7, 1, 1);
    issue(2, 8'h22, 1, 7, 3, 0);
    // R8: ready/busy low past the blanking window stretches the wait
    nf_rb = 0;
    fork begin repeat (200) @(negedge clk4x); nf_rb = 1; end join_none
    issue(0, 8'h90, 0, 0, 0, 0);
    issue(3, 8'h5A, 0, 0, 3, 0);
    repeat (8) @(negedge clk4x);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule